// File: doc/BRIEF.md
# Serial Flash Hold Front End

This block sits at the slave side of a serial memory interface that has an active-low pause pin. It samples the chip-select, serial-clock, pause and data-in pins on a fast system clock. From them it works out when the interface is running, held, or reset by deselection. It passes one enable pulse and one data bit for each accepted rising serial-clock edge to a small word shifter. The shifter gathers bits most-significant first and hands completed words to a command decoder that lies outside this block. It also produces the output-enable for the data-out pad.

A hold begins and ends only while the serial clock is low. A pause-pin edge that arrives while the clock is high takes effect on the next low phase. While held, clock and data-in activity is ignored, the data-out pad floats, and the partial word stays where it was. Deselecting the chip during a hold clears the interface. Another hold is then refused until the pause pin has been released. The internal engine's busy flag passes through this block, and no hold can disturb it.

Top module: `spi_pause_frontend`

## Requirements
- R1: After synchronous reset `hold_active`, `dout_oe`, `shift_en` and `word_valid` are 0 and `bit_pos` is 0.
- R2: While selected (`sel_n_pin` low) and not held, each rising edge of `sck_pin` shifts one `din_pin` bit into the word, most-significant bit first. After `WORD_W` bits `word_valid` pulses for one cycle with the assembled word on `word_data`, and `bit_pos` returns to 0.
- R3: If `pause_n_pin` falls while the chip is selected and `sck_pin` is low, `hold_active` rises and `dout_oe` falls within the synchronizer latency.
- R4: If `pause_n_pin` falls while `sck_pin` is high, the hold does not begin until `sck_pin` next goes low.
- R5: A hold ends when `pause_n_pin` is high and `sck_pin` is low. A rise of `pause_n_pin` while `sck_pin` is high leaves the hold in place until `sck_pin` goes low.
- R6: While held, `sck_pin` and `din_pin` transitions shift nothing and `bit_pos` does not change. After release, shifting continues from the preserved bit position, so the word completes with the correct value.
- R7: A fall of `pause_n_pin` while the chip is deselected does not start a hold.
- R8: Raising `sel_n_pin` during a hold ends the hold, clears `bit_pos` to 0 and discards the partial word. `dout_oe` is 0.
- R9: After a deselection during a hold, or any selection made with `pause_n_pin` already low, no hold starts until `pause_n_pin` has been high. Shifting works meanwhile. Once the pin has been high, a new fall starts a hold again.
- R10: `engine_busy` follows `busy_in` through the synchronizer, whatever the hold state, including across a hold and a reset by deselection.
- R11: `dout_oe` is 1 exactly when the chip is selected and not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_pin | input | 1 | Active-low chip select pin |
| sck_pin | input | 1 | Serial clock pin |
| pause_n_pin | input | 1 | Active-low pause pin |
| din_pin | input | 1 | Serial data-in pin |
| busy_in | input | 1 | Busy flag from the internal write/erase engine |
| hold_active | output | 1 | Interface is in the hold condition |
| shift_en | output | 1 | One-cycle pulse per accepted rising serial-clock edge |
| shift_bit | output | 1 | Data-in bit that goes with `shift_en` |
| dout_oe | output | 1 | Output enable for the data-out pad |
| bit_pos | output | CNT_W | Bits gathered so far in the current word |
| word_valid | output | 1 | One-cycle pulse when a word completes |
| word_data | output | WORD_W | Completed word |
| engine_busy | output | 1 | Synchronized busy flag passed downstream |

## Verification
A scoreboard receives the expected values and compares them with the outputs at each settle point. Plain byte transfers establish the base shift order. Pause edges placed during the low phase of the clock are checked against pause edges placed during the high phase. This separates immediate entry and exit from deferred entry and exit, and it shows whether a clock rise inside a hold is swallowed. Further runs deselect the chip with the pause pin low, both with and without a hold in progress, then reselect with the pin still low. These show reset-and-lockout apart from resume. A final run toggles the busy flag across a hold and a deselection.

// File: rtl/spi_pause_pkg.sv
package spi_pause_pkg;

    typedef enum logic [1:0] {
        HS_RUN  = 2'd0,
        HS_HELD = 2'd1,
        HS_LOCK = 2'd2
    } hold_st_t;

    localparam int PIN_N = 5;

    // Synchronized view of the pins
    typedef struct packed {
        logic sel_n;
        logic sck;
        logic pause_n;
        logic din;
        logic busy;
    } pins_t;

    // Idle level of each pin as seen through the synchronizer after reset
    localparam pins_t PINS_IDLE = '{sel_n: 1'b1, sck: 1'b0, pause_n: 1'b1,
                                    din: 1'b0, busy: 1'b0};

    function automatic logic rise_of(input logic prev, input logic now);
        return !prev && now;
    endfunction

    function automatic logic fall_of(input logic prev, input logic now);
        return prev && !now;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= RST_VAL[i];
                q[i]    <= RST_VAL[i];
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/pause_fsm.sv
module pause_fsm
    import spi_pause_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel_n_s,
    input  logic     sck_s,
    input  logic     pause_n_s,
    output hold_st_t state,
    output logic     held
);
    logic     sel_prev;
    logic     sel_fall;
    hold_st_t nxt;

    assign sel_fall = fall_of(sel_prev, sel_n_s);

    always_comb begin
        nxt = state;
        unique case (state)
            HS_RUN: begin
                if (sel_fall && !pause_n_s)
                    nxt = HS_LOCK;
                else if (!sel_n_s && !pause_n_s && !sck_s)
                    nxt = HS_HELD;
            end
            HS_HELD: begin
                if (sel_n_s)
                    nxt = pause_n_s ? HS_RUN : HS_LOCK;
                else if (pause_n_s && !sck_s)
                    nxt = HS_RUN;
            end
            HS_LOCK: begin
                if (pause_n_s)
                    nxt = HS_RUN;
            end
            default: nxt = HS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= HS_RUN;
            sel_prev <= 1'b1;
        end else begin
            state    <= nxt;
            sel_prev <= sel_n_s;
        end
    end

    assign held = (state == HS_HELD);

    // R4
    entry_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(held) |-> $past(!sck_s));

    // R5
    exit_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(held) && $past(!sel_n_s)) |-> $past(pause_n_s && !sck_s));

    // R9
    lockout_chk: assert property (@(posedge clk) disable iff (rst)
        (state == HS_LOCK && !pause_n_s) |=> !held);

    // R8
    desel_release_chk: assert property (@(posedge clk) disable iff (rst)
        (held && sel_n_s) |=> !held);

    // R7
    no_hold_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(held) |-> $past(!sel_n_s));
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift,
    input  logic              bit_in,
    output logic [CNT_W-1:0]  bit_pos,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sreg;
    logic [WORD_W-1:0] sreg_nxt;

    assign sreg_nxt = {sreg[WORD_W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg       <= '0;
            bit_pos    <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else if (clr) begin
            sreg       <= '0;
            bit_pos    <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (shift) begin
                sreg <= sreg_nxt;
                if (bit_pos == LAST) begin
                    bit_pos    <= '0;
                    word_valid <= 1'b1;
                    word_data  <= sreg_nxt;
                end else begin
                    bit_pos <= bit_pos + 1'b1;
                end
            end
        end
    end

    // R2
    valid_needs_shift_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(shift));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bit_pos == '0));
endmodule

// File: rtl/spi_pause_frontend.sv
module spi_pause_frontend
    import spi_pause_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n_pin,
    input  logic              sck_pin,
    input  logic              pause_n_pin,
    input  logic              din_pin,
    input  logic              busy_in,
    output logic              hold_active,
    output logic              shift_en,
    output logic              shift_bit,
    output logic              dout_oe,
    output logic [CNT_W-1:0]  bit_pos,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              engine_busy
);
    pins_t    raw;
    pins_t    syn;
    logic     sck_prev;
    hold_st_t state;
    logic     held;

    assign raw = '{sel_n: sel_n_pin, sck: sck_pin, pause_n: pause_n_pin,
                   din: din_pin, busy: busy_in};

    pin_sync #(.W(PIN_N), .RST_VAL(PINS_IDLE)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b0;
        else     sck_prev <= syn.sck;
    end

    pause_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .sel_n_s   (syn.sel_n),
        .sck_s     (syn.sck),
        .pause_n_s (syn.pause_n),
        .state     (state),
        .held      (held)
    );

    assign hold_active = held;
    assign shift_en    = rise_of(sck_prev, syn.sck) && !syn.sel_n && !held;
    assign shift_bit   = syn.din;
    assign dout_oe     = !syn.sel_n && !held;
    assign engine_busy = syn.busy;

    word_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk        (clk),
        .rst        (rst),
        .clr        (syn.sel_n),
        .shift      (shift_en),
        .bit_in     (syn.din),
        .bit_pos    (bit_pos),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    // R6
    no_shift_held_chk: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> !shift_en);

    // R3
    oe_off_held_chk: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> !dout_oe);

    // R6
    count_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_active && $past(hold_active)) |-> $stable(bit_pos));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!hold_active && !word_valid && bit_pos == '0));
endmodule

// File: tb/test_spi_pause_frontend.sv
module test_spi_pause_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;
    localparam int SETTLE = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n_pin = 1'b1, sck_pin = 1'b0, pause_n_pin = 1'b1;
    logic din_pin = 1'b0, busy_in = 1'b0;
    logic hold_active, shift_en, shift_bit, dout_oe, word_valid, engine_busy;
    logic [2:0] bit_pos;
    logic [7:0] word_data;

    spi_pause_frontend #(.WORD_W(8)) i_spi_pause_frontend (
        .clk(clk), .rst(rst), .sel_n_pin(sel_n_pin), .sck_pin(sck_pin),
        .pause_n_pin(pause_n_pin), .din_pin(din_pin), .busy_in(busy_in),
        .hold_active(hold_active), .shift_en(shift_en), .shift_bit(shift_bit),
        .dout_oe(dout_oe), .bit_pos(bit_pos), .word_valid(word_valid),
        .word_data(word_data), .engine_busy(engine_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string req;
        int    field;
        int    exp;
    } item_t;

    item_t exp_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    int    n_words  = 0;
    int    last_word = 0;
    bit    done = 1'b0;

    // Independent record of completed words
    always @(negedge clk) begin
        if (!rst && word_valid) begin
            n_words++;
            last_word = int'(word_data);
        end
    end

    function automatic string fname(input int f);
        case (f)
            0: return "hold_active";
            1: return "dout_oe";
            2: return "bit_pos";
            3: return "word_count";
            4: return "last_word";
            5: return "engine_busy";
            default: return "shift_en";
        endcase
    endfunction

    // Monitor: pops expected items and compares with the outputs
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            int act;
            it = exp_q.pop_front();
            case (it.field)
                0: act = int'(hold_active);
                1: act = int'(dout_oe);
                2: act = int'(bit_pos);
                3: act = n_words;
                4: act = last_word;
                5: act = int'(engine_busy);
                default: act = int'(shift_en);
            endcase
            n_checks++;
            if (act != it.exp) begin
                n_fail++;
                $display("FAIL %s %s actual=%0h expected=%0h", it.req,
                         fname(it.field), act, it.exp);
            end
        end
    end

    task automatic expect_val(input string req, input int field, input int exp);
        item_t it;
        it.req = req; it.field = field; it.exp = exp;
        exp_q.push_back(it);
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        din_pin = b;
        wait_sys(HALF);
        sck_pin = 1'b1;
        wait_sys(HALF);
        sck_pin = 1'b0;
        wait_sys(HALF);
    endtask

    task automatic send_bits(input logic [7:0] v, input int msb, input int n);
        for (int i = 0; i < n; i++) send_bit(v[msb - i]);
    endtask

    initial begin
        wait_sys(3);
        rst = 1'b0;
        wait_sys(1);
        // R1 reset state
        expect_val("R1", 0, 0);
        expect_val("R1", 1, 0);
        expect_val("R1", 2, 0);
        expect_val("R1", 6, 0);
        expect_val("R1", 3, 0);

        // R11 selected, not held
        sel_n_pin = 1'b0;
        wait_sys(SETTLE);
        expect_val("R11", 1, 1);

        // R2 full word
        send_bits(8'hA5, 7, 8);
        wait_sys(SETTLE);
        expect_val("R2", 3, 1);
        expect_val("R2", 4, 'hA5);
        expect_val("R2", 2, 0);

        // R3 / R6 / R5 hold with clock low
        send_bits(8'h3C, 7, 3);
        expect_val("R6", 2, 3);
        pause_n_pin = 1'b0;
        wait_sys(SETTLE);
        expect_val("R3", 0, 1);
        expect_val("R3", 1, 0);
        send_bit(1'b1);
        send_bit(1'b0);
        wait_sys(SETTLE);
        expect_val("R6", 2, 3);
        expect_val("R6", 3, 1);
        pause_n_pin = 1'b1;
        wait_sys(SETTLE);
        expect_val("R5", 0, 0);
        expect_val("R11", 1, 1);
        send_bits(8'h3C, 4, 5);
        wait_sys(SETTLE);
        expect_val("R6", 3, 2);
        expect_val("R6", 4, 'h3C);

        // R4 deferred entry: pause falls while clock high
        din_pin = 1'b1;
        wait_sys(HALF);
        sck_pin = 1'b1;
        wait_sys(HALF);
        pause_n_pin = 1'b0;
        wait_sys(SETTLE);
        expect_val("R4", 0, 0);
        expect_val("R4", 2, 1);
        sck_pin = 1'b0;
        wait_sys(SETTLE);
        expect_val("R4", 0, 1);
        // R5 deferred exit: pause rises while clock high
        din_pin = 1'b0;
        sck_pin = 1'b1;
        wait_sys(HALF);
        pause_n_pin = 1'b1;
        wait_sys(SETTLE);
        expect_val("R5", 0, 1);
        expect_val("R6", 2, 1);
        sck_pin = 1'b0;
        wait_sys(SETTLE);
        expect_val("R5", 0, 0);
        send_bits(8'hB3, 6, 7);
        wait_sys(SETTLE);
        expect_val("R6", 3, 3);
        expect_val("R6", 4, 'hB3);

        // R7 pause fall while deselected
        sel_n_pin = 1'b1;
        wait_sys(SETTLE);
        pause_n_pin = 1'b0;
        wait_sys(SETTLE);
        expect_val("R7", 0, 0);
        expect_val("R7", 1, 0);
        pause_n_pin = 1'b1;
        wait_sys(SETTLE);

        // R8 deselect during hold
        sel_n_pin = 1'b0;
        wait_sys(SETTLE);
        send_bits(8'hC0, 7, 2);
        pause_n_pin = 1'b0;
        wait_sys(SETTLE);
        expect_val("R8", 0, 1);
        sel_n_pin = 1'b1;
        wait_sys(SETTLE);
        expect_val("R8", 0, 0);
        expect_val("R8", 1, 0);
        expect_val("R8", 2, 0);

        // R9 reselect with pause still low: no hold, shifting works
        sel_n_pin = 1'b0;
        wait_sys(SETTLE);
        expect_val("R9", 0, 0);
        expect_val("R9", 1, 1);
        send_bits(8'h5A, 7, 8);
        wait_sys(SETTLE);
        expect_val("R9", 3, 4);
        expect_val("R9", 4, 'h5A);
        pause_n_pin = 1'b1;
        wait_sys(SETTLE);
        pause_n_pin = 1'b0;
        wait_sys(SETTLE);
        expect_val("R9", 0, 1);
        pause_n_pin = 1'b1;
        wait_sys(SETTLE);
        sel_n_pin = 1'b1;
        wait_sys(SETTLE);

        // R10 busy flag through hold and reset-by-deselect
        busy_in = 1'b1;
        wait_sys(SETTLE);
        expect_val("R10", 5, 1);
        sel_n_pin = 1'b0;
        wait_sys(SETTLE);
        pause_n_pin = 1'b0;
        wait_sys(SETTLE);
        expect_val("R10", 0, 1);
        expect_val("R10", 5, 1);
        sel_n_pin = 1'b1;
        wait_sys(SETTLE);
        expect_val("R10", 5, 1);
        busy_in = 1'b0;
        wait_sys(SETTLE);
        expect_val("R10", 5, 0);
        pause_n_pin = 1'b1;
        wait_sys(SETTLE);

        wait_sys(3);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule